// File: doc/BRIEF.md
# Unsigned Multiply-Round Accumulator Unit

This datapath unit belongs to a DSP-style coprocessor. It takes two unsigned 16-bit operands and an 8-bit control byte. It forms the 32-bit unsigned product and widens it with zeros to the 40-bit accumulator width. It then writes one of three results into the accumulator: the product unchanged, its two's complement negation over all 40 bits, or a rounded form. The rounded form adds 0x8000 and then zeroes the low 16-bit word. The accumulator is made of 8 guard bits, a high word and a low word.

Each operation is launched by a one-cycle `start` pulse, and the inputs are captured on that edge. One cycle later the accumulator and the status flags update, and `done` pulses for one cycle. The unit keeps six status flags. Negative and zero follow the new accumulator value. Carry and extension are cleared. The two sticky overflow flags (`flag_sv`, `flag_sl`) keep their values. A control byte that is not one of the three legal codes changes nothing and raises `illegal_op` instead. A global multiply-mode input is accepted but has no influence on the result.

Top module: `mul_round_acc`

## Requirements
- R1: With control byte 0x00 (plain), the accumulator receives the 32-bit unsigned product of `op_a` and `op_b`, zero-extended to 40 bits.
- R2: With control byte 0x08 (negate), the accumulator receives 2^40 minus the zero-extended product, taken modulo 2^40, so a zero product gives zero.
- R3: With control byte 0x01 (round), the accumulator receives the zero-extended product plus 0x8000, with bits 15:0 then forced to zero.
- R4: Exactly the three codes 0x00, 0x08 and 0x01 are legal. Each selects only its own mode, so negation and rounding are never combined.
- R5: The `mp_mode` input has no effect on the accumulator or on any flag.
- R6: After a legal operation, `flag_n` equals bit 39 of the new accumulator, and `flag_z` is 1 exactly when all 40 bits are zero.
- R7: After every legal operation, `flag_c` and `flag_e` are 0.
- R8: `flag_sv` and `flag_sl` keep their previous values across every operation.
- R9: For any other control byte, the accumulator and all flags stay unchanged, `illegal_op` is high for exactly one cycle, and `done` stays low.
- R10: Inputs are captured at the clock edge where `start` is high. The accumulator, the flags and a one-cycle `done` pulse (or `illegal_op` pulse) appear at the following edge.
- R11: A synchronous active-high `rst` clears the accumulator, all six flags, `done` and `illegal_op`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse; captures the operands and the control byte |
| op_a | input | 16 | First unsigned operand |
| op_b | input | 16 | Second unsigned operand |
| ctrl | input | 8 | Control byte: 0x00 plain, 0x08 negate, 0x01 round |
| mp_mode | input | 1 | Global multiply-mode setting, ignored by this operation |
| acc | output | 40 | Accumulator: guard bits 39:32, high word 31:16, low word 15:0 |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_sv | output | 1 | Sticky overflow flag |
| flag_e | output | 1 | Extension flag |
| flag_sl | output | 1 | Sticky limit flag |
| done | output | 1 | One-cycle completion pulse for a legal operation |
| illegal_op | output | 1 | One-cycle pulse for an unrecognised control byte |

## Verification
Every result is due at the second rising edge after the bench raises `start`. The first edge captures the inputs, and the second writes the accumulator, the flags and the `done` or `illegal_op` pulse. The bench drives inputs on falling edges. It checks that nothing has changed at the falling edge after the capture edge, reads every result at the falling edge after the update edge, and confirms one edge later that the pulse has dropped. Illegal codes and `mp_mode` changes are judged by comparing the accumulator and flags with the values they held before the stimulus.

// File: rtl/mrac_pkg.sv
package mrac_pkg;

    localparam int DATA_W  = 16;
    localparam int GUARD_W = 8;
    localparam int CTRL_W  = 8;

    localparam logic [CTRL_W-1:0] CODE_PLAIN = 8'h00;
    localparam logic [CTRL_W-1:0] CODE_NEG   = 8'h08;
    localparam logic [CTRL_W-1:0] CODE_RND   = 8'h01;

    typedef enum logic [1:0] {
        MODE_PLAIN = 2'd0,
        MODE_NEG   = 2'd1,
        MODE_RND   = 2'd2,
        MODE_BAD   = 2'd3
    } mode_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic sv;
        logic e;
        logic sl;
    } flags_t;

    function automatic mode_e decode_ctrl(input logic [CTRL_W-1:0] code);
        case (code)
            CODE_PLAIN: return MODE_PLAIN;
            CODE_NEG:   return MODE_NEG;
            CODE_RND:   return MODE_RND;
            default:    return MODE_BAD;
        endcase
    endfunction

endpackage

// File: rtl/mrac_decode.sv
module mrac_decode
    import mrac_pkg::*;
#(
    parameter int CW = CTRL_W
) (
    input  logic [CW-1:0] code,
    output mode_e         mode,
    output logic          legal
);
    always_comb begin
        mode  = decode_ctrl(CTRL_W'(code));
        legal = (mode != MODE_BAD);
    end
endmodule

// File: rtl/mrac_arith.sv
module mrac_arith
    import mrac_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int GW = GUARD_W
) (
    input  logic [DW-1:0]        a,
    input  logic [DW-1:0]        b,
    input  mode_e                mode,
    output logic [2*DW+GW-1:0]   res
);
    localparam int PROD_W = 2 * DW;
    localparam int ACC_W  = PROD_W + GW;
    localparam logic [ACC_W-1:0] RND_ONE  = ACC_W'(1) << (DW - 1);
    localparam logic [ACC_W-1:0] LOW_MASK = {{(ACC_W-DW){1'b0}}, {DW{1'b1}}};

    logic [PROD_W-1:0] prod;
    logic [ACC_W-1:0]  ext;
    logic [ACC_W-1:0]  neg_v;
    logic [ACC_W-1:0]  rnd_v;

    always_comb begin
        prod  = PROD_W'(a) * PROD_W'(b);
        ext   = {{GW{1'b0}}, prod};
        neg_v = '0 - ext;
        rnd_v = (ext + RND_ONE) & ~LOW_MASK;
        unique case (mode)
            MODE_NEG: res = neg_v;
            MODE_RND: res = rnd_v;
            default:  res = ext;
        endcase
    end
endmodule

// File: rtl/mrac_result.sv
module mrac_result
    import mrac_pkg::*;
#(
    parameter int ACC_W = 2 * DATA_W + GUARD_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  logic             legal,
    input  logic [ACC_W-1:0] res,
    output logic [ACC_W-1:0] acc_q,
    output flags_t           flags_q,
    output logic             done_q,
    output logic             bad_q
);
    flags_t nxt_flags;

    always_comb begin
        nxt_flags    = flags_q;
        nxt_flags.n  = res[ACC_W-1];
        nxt_flags.z  = (res == '0);
        nxt_flags.c  = 1'b0;
        nxt_flags.e  = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            flags_q <= '0;
            done_q  <= 1'b0;
            bad_q   <= 1'b0;
        end else begin
            done_q <= fire && legal;
            bad_q  <= fire && !legal;
            if (fire && legal) begin
                acc_q   <= res;
                flags_q <= nxt_flags;
            end
        end
    end
endmodule

// File: rtl/mul_round_acc.sv
module mul_round_acc
    import mrac_pkg::*;
#(
    parameter int DW    = DATA_W,
    parameter int GW    = GUARD_W,
    parameter int CW    = CTRL_W,
    localparam int ACC_W = 2 * DW + GW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DW-1:0]    op_a,
    input  logic [DW-1:0]    op_b,
    input  logic [CW-1:0]    ctrl,
    input  logic             mp_mode,
    output logic [ACC_W-1:0] acc,
    output logic             flag_n,
    output logic             flag_z,
    output logic             flag_c,
    output logic             flag_sv,
    output logic             flag_e,
    output logic             flag_sl,
    output logic             done,
    output logic             illegal_op
);
    logic [DW-1:0]    a_q, b_q;
    logic [CW-1:0]    ctrl_q;
    logic             fire_q;
    mode_e            mode;
    logic             legal;
    logic [ACC_W-1:0] res;
    flags_t           flags;
    logic             unused_mp;

    assign unused_mp = mp_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q    <= '0;
            b_q    <= '0;
            ctrl_q <= '0;
            fire_q <= 1'b0;
        end else begin
            fire_q <= start;
            if (start) begin
                a_q    <= op_a;
                b_q    <= op_b;
                ctrl_q <= ctrl;
            end
        end
    end

    mrac_decode #(.CW(CW)) u_dec (
        .code  (ctrl_q),
        .mode  (mode),
        .legal (legal)
    );

    mrac_arith #(.DW(DW), .GW(GW)) u_arith (
        .a    (a_q),
        .b    (b_q),
        .mode (mode),
        .res  (res)
    );

    mrac_result #(.ACC_W(ACC_W)) u_res (
        .clk     (clk),
        .rst     (rst),
        .fire    (fire_q),
        .legal   (legal),
        .res     (res),
        .acc_q   (acc),
        .flags_q (flags),
        .done_q  (done),
        .bad_q   (illegal_op)
    );

    assign flag_n  = flags.n;
    assign flag_z  = flags.z;
    assign flag_c  = flags.c;
    assign flag_sv = flags.sv;
    assign flag_e  = flags.e;
    assign flag_sl = flags.sl;
endmodule

// File: rtl/mrac_checker.sv
module mrac_checker
    import mrac_pkg::*;
#(
    parameter int DW    = DATA_W,
    parameter int CW    = CTRL_W,
    parameter int ACC_W = 2 * DATA_W + GUARD_W
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [CW-1:0]    ctrl,
    input logic [ACC_W-1:0] acc,
    input logic             flag_n,
    input logic             flag_z,
    input logic             flag_c,
    input logic             flag_sv,
    input logic             flag_e,
    input logic             flag_sl,
    input logic             done,
    input logic             illegal_op
);
    // R3: round mode leaves the low word at zero
    a_r3_round_low_clear: assert property (@(posedge clk) disable iff (rst)
        (start && ctrl == CW'(CODE_RND)) |=> ##1 (done && acc[DW-1:0] == '0));

    // R6: negative flag tracks the top accumulator bit after an operation
    a_r6_neg_flag: assert property (@(posedge clk) disable iff (rst)
        done |-> (flag_n == acc[ACC_W-1]));

    // R7: carry and extension cleared after each operation
    a_r7_c_e_clear: assert property (@(posedge clk) disable iff (rst)
        done |-> (!flag_c && !flag_e));

    // R8: sticky flags never move outside reset
    a_r8_sticky_hold: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($stable(flag_sv) && $stable(flag_sl)));

    // R9: an illegal code leaves the accumulator and flags alone
    a_r9_illegal_hold: assert property (@(posedge clk) disable iff (rst)
        illegal_op |-> ($stable(acc) && $stable(flag_n) && $stable(flag_z)
                        && $stable(flag_c) && $stable(flag_e)));

    // R9: illegal and done never together
    a_r9_no_done: assert property (@(posedge clk) disable iff (rst)
        illegal_op |-> !done);

    // R10: every launch answers exactly two edges later
    a_r10_answer: assert property (@(posedge clk) disable iff (rst)
        start |=> ##1 (done || illegal_op));

    // R11: reset clears the accumulator and flags
    a_r11_reset_clear: assert property (@(posedge clk)
        rst |=> (acc == '0 && !flag_n && !flag_z && !flag_c && !flag_sv
                 && !flag_e && !flag_sl && !done && !illegal_op));
endmodule

bind mul_round_acc mrac_checker #(.DW(DW), .CW(CW), .ACC_W(ACC_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .ctrl       (ctrl),
    .acc        (acc),
    .flag_n     (flag_n),
    .flag_z     (flag_z),
    .flag_c     (flag_c),
    .flag_sv    (flag_sv),
    .flag_e     (flag_e),
    .flag_sl    (flag_sl),
    .done       (done),
    .illegal_op (illegal_op)
);

// File: tb/test_mul_round_acc.sv
`timescale 1ns/1ps
module test_mul_round_acc;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [15:0] op_a, op_b;
    logic [7:0]  ctrl;
    logic        mp_mode;
    logic [39:0] acc;
    logic        flag_n, flag_z, flag_c, flag_sv, flag_e, flag_sl;
    logic        done, illegal_op;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    mul_round_acc i_mul_round_acc (
        .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
        .ctrl(ctrl), .mp_mode(mp_mode), .acc(acc),
        .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_sv(flag_sv),
        .flag_e(flag_e), .flag_sl(flag_sl), .done(done), .illegal_op(illegal_op)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [39:0] ext_prod(input logic [15:0] a, input logic [15:0] b);
        logic [39:0] x;
        x = 40'(a) * 40'(b);
        return x;
    endfunction

    // launch; returns after the falling edge that follows the update edge
    task automatic launch(input logic [15:0] a, input logic [15:0] b,
                          input logic [7:0] c, input logic mp);
        logic [39:0] acc_before;
        @(negedge clk);
        acc_before = acc;
        op_a = a; op_b = b; ctrl = c; mp_mode = mp; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        op_a = ~a; op_b = ~b; ctrl = 8'h08; mp_mode = ~mp;
        check(!done && !illegal_op && acc == acc_before, "R10 early",
              {23'd0, done, illegal_op, acc}, {25'd0, acc_before});
        @(negedge clk);
    endtask

    task automatic expect_legal(input string req, input logic [39:0] exp);
        check(acc == exp, req, acc, exp);
        check(done && !illegal_op, "R10 done pulse", {done, illegal_op}, 2'b10);
        check(flag_n == exp[39] && flag_z == (exp == 40'd0), "R6 n/z",
              {flag_n, flag_z}, {exp[39], exp == 40'd0});
        check(!flag_c && !flag_e, "R7 c/e", {flag_c, flag_e}, 2'b00);
        check(!flag_sv && !flag_sl, "R8 sv/sl", {flag_sv, flag_sl}, 2'b00);
        @(negedge clk);
        check(!done, "R10 done one cycle", done, 0);
    endtask

    task automatic t_reset;
        rst = 1'b1; start = 1'b0; op_a = '0; op_b = '0; ctrl = '0; mp_mode = 1'b0;
        repeat (3) @(negedge clk);
        check(acc == 40'd0 && !flag_n && !flag_z && !flag_c && !flag_sv && !flag_e
              && !flag_sl && !done && !illegal_op, "R11 reset",
              {acc, flag_n, flag_z, flag_c, flag_sv, flag_e, flag_sl, done, illegal_op}, 0);
        rst = 1'b0;
    endtask

    task automatic t_plain;
        launch(16'h1234, 16'h5678, 8'h00, 1'b0);
        expect_legal("R1 plain", ext_prod(16'h1234, 16'h5678));
        launch(16'hFFFF, 16'hFFFF, 8'h00, 1'b0);
        expect_legal("R1 plain max", 40'h00_FFFE_0001);
        launch(16'h0000, 16'hBEEF, 8'h00, 1'b0);
        expect_legal("R1 plain zero", 40'd0);
    endtask

    task automatic t_negate;
        launch(16'h0003, 16'h0005, 8'h08, 1'b0);
        expect_legal("R2 negate", 40'hFF_FFFF_FFF1);
        launch(16'hFFFF, 16'hFFFF, 8'h08, 1'b0);
        expect_legal("R2 negate max", 40'hFF_0001_FFFF);
        launch(16'h0000, 16'h0000, 8'h08, 1'b0);
        expect_legal("R2 negate zero", 40'd0);
    endtask

    task automatic t_round;
        launch(16'h1234, 16'h5678, 8'h01, 1'b0);
        expect_legal("R3 round", (ext_prod(16'h1234, 16'h5678) + 40'h8000) & ~40'hFFFF);
        launch(16'hFFFF, 16'hFFFF, 8'h01, 1'b0);
        expect_legal("R3 round max", 40'h00_FFFE_0000);
        launch(16'h0001, 16'h7FFF, 8'h01, 1'b0);
        expect_legal("R3 round below half", 40'd0);
        launch(16'h0001, 16'h8000, 8'h01, 1'b0);
        expect_legal("R3 round half", 40'h00_0001_0000);
    endtask

    task automatic t_codes;
        // R4: 0x09 would be negate+round combined; it must be rejected
        launch(16'h0100, 16'h0100, 8'h00, 1'b0);
        expect_legal("R4 setup", 40'h00_0001_0000);
        launch(16'h0200, 16'h0300, 8'h09, 1'b0);
        check(illegal_op && !done, "R4 combined code rejected", {illegal_op, done}, 2'b10);
        check(acc == 40'h00_0001_0000, "R4 combined acc kept", acc, 40'h00_0001_0000);
        @(negedge clk);
    endtask

    task automatic t_mp;
        launch(16'hA5A5, 16'h5A5A, 8'h08, 1'b1);
        expect_legal("R5 mp negate", 40'd0 - ext_prod(16'hA5A5, 16'h5A5A));
        launch(16'hA5A5, 16'h5A5A, 8'h01, 1'b1);
        expect_legal("R5 mp round", (ext_prod(16'hA5A5, 16'h5A5A) + 40'h8000) & ~40'hFFFF);
    endtask

    task automatic t_illegal;
        logic [39:0] keep;
        logic        kn, kz;
        launch(16'h0007, 16'h0009, 8'h08, 1'b0);
        expect_legal("R9 setup", 40'd0 - 40'd63);
        keep = acc; kn = flag_n; kz = flag_z;
        foreach (keep[i]) begin end
        for (int k = 0; k < 4; k++) begin
            logic [7:0] code;
            code = (k == 0) ? 8'h02 : (k == 1) ? 8'h80 : (k == 2) ? 8'hFF : 8'h10;
            launch(16'h0000, 16'h0000, code, 1'b0);
            check(illegal_op && !done, "R9 pulse", {illegal_op, done}, 2'b10);
            check(acc == keep && flag_n == kn && flag_z == kz && !flag_c && !flag_e
                  && !flag_sv && !flag_sl, "R9 state kept",
                  {acc, flag_n, flag_z}, {keep, kn, kz});
            @(negedge clk);
            check(!illegal_op, "R9 one cycle", illegal_op, 0);
        end
    endtask

    task automatic t_reset_mid;
        launch(16'hFFFF, 16'h0002, 8'h08, 1'b0);
        expect_legal("R11 setup", 40'd0 - 40'h1FFFE);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(acc == 40'd0 && !flag_n && !flag_z, "R11 reset after use",
              {acc, flag_n, flag_z}, 0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_plain();
                t_negate();
                t_round();
                t_codes();
                t_mp();
                t_illegal();
                t_reset_mid();
            end
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=hung expected=finished");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule